// File: doc/BRIEF.md
# Local interrupt controller countdown timer

This block is the programmable timer of a per-core local interrupt controller. Software programs three registers through a small write port: a timer entry that holds the interrupt vector, a mask bit and a mode bit; a divide configuration; and an initial count. A fourth register select reads back the current count. The free-running base clock is divided by a power of two. Each divided tick moves the timer one step through its period of (initial count + 1) ticks. Writing the initial count records "now" as the load time and starts the timer.

In one-shot mode the timer expires once, (initial count + 1) divided ticks after the load. In periodic mode it expires at every multiple of that period after the load. Each expiry that is not masked produces a one-cycle interrupt request that carries the programmed vector. An initial count of zero never expires. Changing the mask or mode bits does not reload the count. The schedule is always taken from the stored load time, so a change of mode takes effect at the next tick boundary that the new mode allows.

Top module: `lapic_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide configuration, initial count and current count read 0, and `irq_valid` is low. The latched divide shift is 0.
- R2: The divide code is {wr_data[3], wr_data[1:0]}. Codes 0 to 6 divide the base clock by 2^(code+1) and code 7 divides by 1. With initial count N, a one-shot expiry appears (N+1)·2^shift cycles after the load edge.
- R3: In one-shot mode with a nonzero initial count N, exactly one pulse appears: `irq_valid` is high in the cycle after the edge where (N+1)·2^shift base cycles have elapsed since the load edge, with `irq_vector` equal to the entry's bits 7:0.
- R4: In one-shot mode the current count (select 3) reads N − d, where d is the number of elapsed divided ticks, and reads 0 once d ≥ N+1.
- R5: In periodic mode with N ≠ 0, a pulse follows every edge where the elapsed base cycles are a nonzero multiple of (N+1)·2^shift. The current count reads N − (d mod (N+1)).
- R6: An initial count of 0 never raises `irq_valid` in either mode, and the current count reads 0.
- R7: When the mask bit (bit 16) is set at an expiry edge, that expiry is dropped. Unmasking later raises no pulse for it, and the count keeps running.
- R8: Writing the initial count while the timer runs restarts the schedule from that write edge. No pulse is raised on the write edge itself.
- R9: Writing the mode bit (bit 17) keeps the load time. A one-shot timer that already expired and is switched to periodic pulses at the next period multiple. A periodic timer that already expired once and is switched to one-shot pulses no more.
- R10: The divide shift is latched from the divide configuration at each initial-count write. Changing the divide configuration while the timer runs has no effect until the next load.
- R11: Every interrupt request lasts exactly one cycle.
- R12: Register readback places the vector in bits 7:0, the mask in bit 16 and the mode in bit 17, with other bits 0. The divide configuration reads back in bits 3, 1 and 0. Writes to select 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, also the timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 entry, 1 divide, 2 initial count, 3 ignored |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read select: 0 entry, 1 divide, 2 initial count, 3 current count |
| rd_data | output | DATA_W | Combinational readback of the selected register |
| irq_valid | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | VEC_W | Vector that goes with irq_valid |

## Verification
A write takes effect at the clock edge that follows its strobe. The readback of a register, and the current count, can therefore be seen combinationally in the next cycle. An expiry is decided at the edge where the elapsed base-cycle count reaches the boundary, and `irq_valid` is registered, so the pulse is visible in the cycle after that edge and uses the mask, mode and vector that were in force before it. The bench counts clock edges since the last load and derives the expected pulse and count for the cycle after each edge from closed formulas. It samples a few time units after the falling edge, when every register and the combinational readback have settled.

// File: rtl/lapic_timer.sv
module lapic_timer #(
  parameter int DATA_W    = 32,
  parameter int VEC_W     = 8,
  parameter int MAX_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int SH_W     = $clog2(MAX_SHIFT + 1);
  localparam int PRE_W    = MAX_SHIFT;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;
  localparam logic [1:0] SEL_LVT = 2'd0, SEL_DIV = 2'd1, SEL_INIT = 2'd2;

  logic [VEC_W-1:0]  vec_q;
  logic              mask_q, per_q, wrapped_q;
  logic [2:0]        div_q;
  logic [SH_W-1:0]   shift_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] init_q, phase_q;

  function automatic logic [SH_W-1:0] code_shift(input logic [2:0] c);
    return (c == 3'd7) ? '0 : SH_W'(c) + SH_W'(1);
  endfunction

  logic              load, running, tick, expire, fire;
  logic [PRE_W-1:0]  pre_nx, div_mask;
  logic [DATA_W-1:0] cur_cnt;

  assign load     = wr_en && (wr_sel == SEL_INIT);
  assign running  = (init_q != '0);
  assign pre_nx   = pre_q + PRE_W'(1);
  assign div_mask = ~({PRE_W{1'b1}} << shift_q);
  assign tick     = ((pre_nx & div_mask) == '0);
  assign expire   = running && tick && (phase_q == '0) && (per_q || !wrapped_q);
  assign fire     = expire && !mask_q && !load;
  assign cur_cnt  = (per_q || !wrapped_q) ? phase_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      div_q      <= '0;
      shift_q    <= '0;
      pre_q      <= '0;
      init_q     <= '0;
      phase_q    <= '0;
      wrapped_q  <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= fire;
      irq_vector <= vec_q;
      if (wr_en && wr_sel == SEL_LVT) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[MASK_BIT];
        per_q  <= wr_data[MODE_BIT];
      end
      if (wr_en && wr_sel == SEL_DIV)
        div_q <= {wr_data[3], wr_data[1:0]};
      if (load) begin
        init_q    <= wr_data;
        phase_q   <= wr_data;
        pre_q     <= '0;
        wrapped_q <= 1'b0;
        shift_q   <= code_shift(div_q);
      end else if (running) begin
        pre_q <= pre_nx;
        if (tick) begin
          if (phase_q == '0) begin
            phase_q   <= init_q;
            wrapped_q <= 1'b1;
          end else begin
            phase_q <= phase_q - DATA_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: begin
        rd_data[VEC_W-1:0] = vec_q;
        rd_data[MASK_BIT]  = mask_q;
        rd_data[MODE_BIT]  = per_q;
      end
      2'd1:    rd_data[3:0] = {div_q[2], 1'b0, div_q[1:0]};
      2'd2:    rd_data = init_q;
      default: rd_data = cur_cnt;
    endcase
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R11
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q)); // R7
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |=> !irq_valid); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= init_q); // R4
  AST_ONESHOT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !per_q && !$past(wr_en)) |-> (cur_cnt == '0)); // R3
endmodule

// File: tb/lapic_timer_bench.sv
module lapic_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  always #10 clk = ~clk;

  lapic_timer u_lapic_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    run_chk = 1'b0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int shift_of(input int code);
    return (code == 7) ? 0 : code + 1;
  endfunction

  // reference model from the requirements: edges since load
  longint edge_n, load_e, e, d, plen, p;
  int     m_code, m_sh;
  bit     m_mask, m_per;
  logic [7:0]  m_vec;
  logic [31:0] m_init;
  bit          exp_irq;
  logic [7:0]  exp_vec;
  longint      exp_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      edge_n = 0; load_e = 0; m_code = 0; m_sh = 0; m_mask = 1; m_per = 0;
      m_vec = 0; m_init = 0; exp_irq = 0; exp_vec = 0; exp_cnt = 0;
    end else begin
      edge_n++;
      e = edge_n - load_e;
      plen = (longint'(m_init) + 1) << m_sh;
      if (wr_en && wr_sel == 2'd2) exp_irq = 0;
      else exp_irq = (m_init != 0) && !m_mask && e > 0 &&
                     (m_per ? (e % plen == 0) : (e == plen));
      exp_vec = m_vec;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_vec = wr_data[7:0]; m_mask = wr_data[16]; m_per = wr_data[17]; end
          2'd1: m_code = {wr_data[3], wr_data[1:0]};
          2'd2: begin m_init = wr_data; load_e = edge_n; m_sh = shift_of(m_code); end
          default: ;
        endcase
      end
      e = edge_n - load_e;
      d = e >> m_sh;
      p = longint'(m_init) + 1;
      if (m_per) exp_cnt = longint'(m_init) - (d % p);
      else exp_cnt = (d >= p) ? 0 : longint'(m_init) - d;
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && run_chk && !done) begin
      chk(irq_valid == exp_irq, tag, irq_valid, exp_irq);
      if (exp_irq && irq_valid) chk(irq_vector == exp_vec, tag, irq_vector, exp_vec);
      if (rd_sel == 2'd3) chk(rd_data == 32'(exp_cnt), tag, rd_data, exp_cnt);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] v, input string req);
    @(negedge clk);
    rd_sel = s;
    #2;
    chk(rd_data == v, req, rd_data, v);
    #2;
    rd_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int pulses;
  task automatic count_pulses(input int n);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      if (irq_valid) pulses++;
    end
  endtask

  initial begin
    int lat;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(irq_valid == 1'b0, "R1 irq", irq_valid, 0);
    rd_chk(2'd0, 32'h0001_0000, "R1 entry");
    rd_chk(2'd1, 32'h0, "R1 divide");
    rd_chk(2'd2, 32'h0, "R1 init");
    rd_chk(2'd3, 32'h0, "R1 count");
    run_chk = 1'b1;

    tag = "R12";
    wr(2'd0, 32'hFFFF_FF55);
    rd_chk(2'd0, 32'h0003_0055, "R12 entry fields");
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h0000_000B, "R12 divide fields");
    wr(2'd2, 32'd0);
    wr(2'd3, 32'h1234_5678);
    rd_chk(2'd2, 32'h0, "R12 select 3 write ignored");
    rd_chk(2'd0, 32'h0003_0055, "R12 select 3 write ignored");

    tag = "R3";
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'h0000_0041);
    wr(2'd2, 32'd5);
    idle(20);
    tag = "R4";
    wr(2'd2, 32'd9);
    idle(20);

    tag = "R2";
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, {28'd0, c[2], 1'b0, c[1:0]});
      wr(2'd0, 32'h0000_0022);
      wr(2'd2, 32'd2);
      lat = -1;
      for (int k = 1; k <= 500 && lat < 0; k++) begin
        @(negedge clk); #2;
        if (irq_valid) lat = k;
      end
      chk(lat == (3 << shift_of(c)), "R2 latency", lat, 3 << shift_of(c));
      idle(4);
    end

    tag = "R6";
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'h0002_0010);
    wr(2'd2, 32'd0);
    count_pulses(300);
    chk(pulses == 0, "R6 periodic zero", pulses, 0);
    wr(2'd0, 32'h0000_0010);
    count_pulses(50);
    chk(pulses == 0, "R6 one-shot zero", pulses, 0);

    tag = "R5";
    wr(2'd0, 32'h0002_0033);
    wr(2'd2, 32'd4);
    count_pulses(50);
    chk(pulses == 10, "R5 periodic pulses", pulses, 10);
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'd3);
    idle(70);

    tag = "R7";
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'h0003_0044);
    wr(2'd2, 32'd3);
    count_pulses(14);
    chk(pulses == 0, "R7 masked", pulses, 0);
    wr(2'd0, 32'h0002_0044);
    idle(20);

    tag = "R8";
    wr(2'd2, 32'd6);
    idle(4);
    wr(2'd2, 32'd6);
    idle(4);
    wr(2'd2, 32'd6);
    idle(30);

    tag = "R9";
    wr(2'd0, 32'h0000_0055);
    wr(2'd2, 32'd3);
    idle(8);
    wr(2'd0, 32'h0002_0055);
    idle(20);
    wr(2'd0, 32'h0000_0055);
    count_pulses(40);
    chk(pulses == 0, "R9 periodic to one-shot", pulses, 0);

    tag = "R10";
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'h0002_0066);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'h0000_0002);
    count_pulses(20);
    chk(pulses == 5, "R10 divide held until load", pulses, 5);
    wr(2'd2, 32'd3);
    idle(60);

    tag = "R11";
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'h0002_0077);
    wr(2'd2, 32'd1);
    idle(20);

    tag = "R5 random";
    for (int it = 0; it < 2500; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 3) wr(2'd0, {14'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), 8'd0, 8'($urandom)});
      else if (op < 5) wr(2'd1, ($urandom_range(0, 2) == 0) ? 32'h0 : (($urandom_range(0, 1) == 0) ? 32'hB : 32'($urandom)));
      else if (op < 9) wr(2'd2, 32'($urandom_range(0, 12)));
      else wr(2'd3, 32'($urandom));
      idle(int'($urandom_range(0, 40)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule